// File: doc/BRIEF.md
# Transpose-Form Adaptive FIR Filter (LMS)

This block is an N-tap adaptive FIR filter laid out in transpose form. Every accepted input sample is sent at once to all tap multipliers. The products then move along a chain of registered adders, and the output appears at the head of that chain. Each tap weight adapts with a least-mean-square rule. The step size is a power-of-two fraction and is applied as an arithmetic right shift, so no multiplier is needed for it.

Because the adder line is registered, the weight of tap k that reaches today's output was the weight in force k samples ago. The filter is therefore a delayed-LMS structure by nature. A parameter chooses between two variants:
- Immediate adaptation. The error of the current sample updates the weights at the same clock edge.
- Two-sample adaptation delay. A register sits after the output and another after the error. This shortens the feedback path, and the weight update then reads a longer copy of the input history.

Samples, weights and the desired response are signed fixed-point values with L-1 fraction bits. All state moves only on cycles where the input strobe is high.

Top module: `lms_tf_filter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every weight, every adder-line register, the input history and the output registers to zero, so `y_out` and `e_out` read 0 afterwards.
- R2: For an accepted sample n, `y_out` (delay 0 or 2, valid after that sample's edge) equals floor(Σ_k x[n-k]·w_k / 2^(L-1)), where w_k is tap k's weight as it stood when sample n-k was accepted.
- R3: The error is output minus desired. With delay 0, `e_out` after sample n's edge equals y[n] − d[n]. With delay 2, `e_out` after sample n's edge equals y[n-1] − d[n-1].
- R4: With delay 0, at sample n's edge each tap k updates as w_k ← sat(w_k − ((c(e[n]) · x[n-k]) >>> (L-1))), where c(e) = clamp(e >>> MU_SHIFT).
- R5: With delay 2, the same update uses e[n-2] and x[n-2-k] in place of e[n] and x[n-k].
- R6: A weight that would leave the signed L-bit range is held at −2^(L-1) or 2^(L-1)−1.
- R7: On a cycle with `in_valid` low, no weight, adder-line register, input history or output changes, whatever `x_in` and `d_in` carry.
- R8: The scaled error c(e) is clamped to the signed L-bit range before it multiplies the sample.
- R9: Only adaptation delays 0 and 2 elaborate; any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; all state advances only when high |
| x_in | input | L | Signed input sample |
| d_in | input | L | Signed desired response |
| y_out | output | L+2+⌈log2(N+1)⌉ − 1 | Filter output, scaled back to sample units |
| e_out | output | L+2+⌈log2(N+1)⌉ | Error, output minus desired |

## Verification
The bench builds the filter twice, once with adaptation delay 0 and once with delay 2. Both builds use L=10, N=5 and MU_SHIFT=2. A 10-bit word lets a few strongly biased samples drive the weights into saturation and push the shifted error past the clamp limit, so R6 and R8 are reached within tens of samples. Five taps make ⌈log2(N+1)⌉ round up rather than fall exactly on a power of two. Having both delay variants in one run compares the lagged error and the longer input history of the delayed variant against a reference model over the same stimulus.

// File: rtl/lms_tf_pkg.sv
package lms_tf_pkg;

   // Adaptation delays the structure can be built with
   localparam int DELAY_NONE = 0;
   localparam int DELAY_TWO  = 2;

   function automatic bit delay_supported(input int m);
      return (m == DELAY_NONE) || (m == DELAY_TWO);
   endfunction

   // Accumulator width of the adder line for a given word and tap count
   function automatic int line_width(input int wl, input int taps);
      return 2 * wl + $clog2(taps + 1);
   endfunction

endpackage

// File: rtl/lms_tf_xline.sv
// Input history: stage j holds the sample accepted j+1 strobes ago.
module lms_tf_xline #(
   parameter int L     = 16,
   parameter int DEPTH = 7
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       valid,
   input  logic [L-1:0]               x_in,
   output logic [DEPTH-1:0][L-1:0]    x_dly
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("lms_tf_xline: DEPTH must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         x_dly <= '0;
      end else if (valid) begin
         x_dly[0] <= x_in;
         for (int j = 1; j < DEPTH; j++) begin
            x_dly[j] <= x_dly[j-1];
         end
      end
   end

   // R7: the history freezes when no sample is offered
   a_r7_history_hold: assert property (@(posedge clk) disable iff (rst)
      !valid |=> $stable(x_dly));

   // R1: reset empties the history
   a_r1_history_clear: assert property (@(posedge clk)
      rst |=> (x_dly == '0));
endmodule

// File: rtl/lms_tf_tap.sv
// One tap: weight register with saturating LMS update, product onto the adder line.
module lms_tf_tap #(
   parameter int L       = 16,
   parameter int AW      = 36,
   parameter bit HAS_REG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 valid,
   input  logic signed [L-1:0]  x_now,
   input  logic signed [L-1:0]  x_upd,
   input  logic signed [L-1:0]  step_err,
   input  logic signed [AW-1:0] line_in,
   output logic signed [AW-1:0] line_out
);
   localparam int PW = 2 * L;
   localparam logic signed [L+1:0] W_MAX = (L+2)'((2 ** (L-1)) - 1);
   localparam logic signed [L+1:0] W_MIN = -(L+2)'(2 ** (L-1));

   if (AW < PW) begin : g_bad_width
      $error("lms_tf_tap: AW must cover the full product");
   end

   logic signed [L-1:0]  w_q;
   logic signed [PW-1:0] prod;
   logic signed [AW-1:0] sum;
   logic signed [PW-1:0] corr;
   logic signed [L:0]    inc;
   logic signed [L+1:0]  w_wide;
   logic signed [L-1:0]  w_next;

   assign prod = x_now * w_q;
   assign sum  = line_in + AW'(prod);

   // Weight correction: scaled error times the aligned sample, back in weight units
   assign corr   = step_err * x_upd;
   assign inc    = (L+1)'(corr >>> (L-1));
   assign w_wide = (L+2)'(w_q) - (L+2)'(inc);

   always_comb begin
      if (w_wide > W_MAX)      w_next = L'(W_MAX);
      else if (w_wide < W_MIN) w_next = L'(W_MIN);
      else                     w_next = L'(w_wide);
   end

   always_ff @(posedge clk) begin
      if (rst)        w_q <= '0;
      else if (valid) w_q <= w_next;
   end

   if (HAS_REG) begin : g_reg
      logic signed [AW-1:0] line_q;
      always_ff @(posedge clk) begin
         if (rst)        line_q <= '0;
         else if (valid) line_q <= sum;
      end
      assign line_out = line_q;

      a_r7_line_hold: assert property (@(posedge clk) disable iff (rst)
         !valid |=> $stable(line_q));
   end else begin : g_head
      assign line_out = sum;
   end

   // R7: weight frozen without a strobe
   a_r7_weight_hold: assert property (@(posedge clk) disable iff (rst)
      !valid |=> $stable(w_q));

   // R4: a zero scaled error leaves the weight untouched
   a_r4_zero_step_keeps: assert property (@(posedge clk) disable iff (rst)
      (valid && step_err == '0) |=> $stable(w_q));

   // R1: reset clears the weight
   a_r1_weight_clear: assert property (@(posedge clk)
      rst |=> (w_q == '0));
endmodule

// File: rtl/lms_tf_err.sv
// Output scaling, error subtraction, step-size shift and clamp; delay variant chosen here.
module lms_tf_err #(
   parameter int L        = 16,
   parameter int AW       = 36,
   parameter int YW       = 21,
   parameter int EW       = 22,
   parameter int MU_SHIFT = 4,
   parameter int DELAY    = 0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 valid,
   input  logic signed [AW-1:0] acc,
   input  logic signed [L-1:0]  d,
   output logic signed [YW-1:0] y_o,
   output logic signed [EW-1:0] e_o,
   output logic signed [L-1:0]  step_err
);
   localparam logic signed [EW-1:0] S_MAX = EW'((2 ** (L-1)) - 1);
   localparam logic signed [EW-1:0] S_MIN = -EW'(2 ** (L-1));

   logic signed [YW-1:0] y_now;
   logic signed [EW-1:0] e_src;
   logic signed [EW-1:0] e_shift;

   assign y_now = YW'(acc >>> (L-1));

   if (DELAY == 0) begin : g_d0
      logic signed [YW-1:0] y_q;
      logic signed [EW-1:0] e_q;
      logic signed [EW-1:0] e_now;
      assign e_now = EW'(y_now) - EW'(d);
      always_ff @(posedge clk) begin
         if (rst) begin
            y_q <= '0;
            e_q <= '0;
         end else if (valid) begin
            y_q <= y_now;
            e_q <= e_now;
         end
      end
      assign e_src = e_now;
      assign y_o   = y_q;
      assign e_o   = e_q;
   end else begin : g_d2
      logic signed [YW-1:0] y_q;
      logic signed [L-1:0]  d_q;
      logic signed [EW-1:0] e_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            y_q <= '0;
            d_q <= '0;
            e_q <= '0;
         end else if (valid) begin
            y_q <= y_now;
            d_q <= d;
            e_q <= EW'(y_q) - EW'(d_q);
         end
      end
      assign e_src = e_q;
      assign y_o   = y_q;
      assign e_o   = e_q;
   end

   assign e_shift = e_src >>> MU_SHIFT;

   always_comb begin
      if (e_shift > S_MAX)      step_err = L'(S_MAX);
      else if (e_shift < S_MIN) step_err = L'(S_MIN);
      else                      step_err = L'(e_shift);
   end

   // R7: outputs hold without a strobe
   a_r7_out_hold: assert property (@(posedge clk) disable iff (rst)
      !valid |=> ($stable(y_o) && $stable(e_o)));

   // R8: clamped step never flips the sign of the error
   a_r8_step_sign: assert property (@(posedge clk) disable iff (rst)
      (e_src > 0 |-> step_err >= 0) and (e_src < 0 |-> step_err <= 0));

   // R1: reset clears the outputs
   a_r1_out_clear: assert property (@(posedge clk)
      rst |=> (y_o == '0 && e_o == '0));
endmodule

// File: rtl/lms_tf_filter.sv
module lms_tf_filter
   import lms_tf_pkg::*;
#(
   parameter int L           = 16,
   parameter int N           = 8,
   parameter int MU_SHIFT    = 4,
   parameter int ADAPT_DELAY = 0,
   localparam int AW = line_width(L, N),
   localparam int YW = AW - L + 1,
   localparam int EW = YW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [L-1:0]  x_in,
   input  logic [L-1:0]  d_in,
   output logic [YW-1:0] y_out,
   output logic [EW-1:0] e_out
);
   localparam int XD = N - 1 + ADAPT_DELAY;

   // R9: elaboration-time parameter checks
   if (!delay_supported(ADAPT_DELAY)) begin : g_bad_delay
      $error("lms_tf_filter: ADAPT_DELAY must be 0 or 2");
   end
   if (N < 2) begin : g_bad_taps
      $error("lms_tf_filter: N must be at least 2");
   end
   if (L < 2) begin : g_bad_word
      $error("lms_tf_filter: L must be at least 2");
   end
   if (MU_SHIFT < 0 || MU_SHIFT >= EW) begin : g_bad_mu
      $error("lms_tf_filter: MU_SHIFT out of range");
   end

   logic [XD-1:0][L-1:0]  x_dly;
   logic signed [AW-1:0]  line [N+1];
   logic signed [L-1:0]   step_err;
   logic signed [YW-1:0]  y_s;
   logic signed [EW-1:0]  e_s;

   assign line[N] = '0;

   lms_tf_xline #(.L(L), .DEPTH(XD)) u_xline (
      .clk   (clk),
      .rst   (rst),
      .valid (in_valid),
      .x_in  (x_in),
      .x_dly (x_dly)
   );

   for (genvar k = 0; k < N; k++) begin : g_tap
      logic signed [L-1:0] x_upd;
      if (ADAPT_DELAY == 0) begin : g_now
         if (k == 0) begin : g_first
            assign x_upd = x_in;
         end else begin : g_rest
            assign x_upd = x_dly[k-1];
         end
      end else begin : g_late
         assign x_upd = x_dly[k+1];
      end

      lms_tf_tap #(.L(L), .AW(AW), .HAS_REG(k != 0)) u_tap (
         .clk      (clk),
         .rst      (rst),
         .valid    (in_valid),
         .x_now    (x_in),
         .x_upd    (x_upd),
         .step_err (step_err),
         .line_in  (line[k+1]),
         .line_out (line[k])
      );
   end

   lms_tf_err #(
      .L(L), .AW(AW), .YW(YW), .EW(EW), .MU_SHIFT(MU_SHIFT), .DELAY(ADAPT_DELAY)
   ) u_err (
      .clk      (clk),
      .rst      (rst),
      .valid    (in_valid),
      .acc      (line[0]),
      .d        (d_in),
      .y_o      (y_s),
      .e_o      (e_s),
      .step_err (step_err)
   );

   assign y_out = y_s;
   assign e_out = e_s;
endmodule

// File: tb/lms_tf_filter_tb_top.sv
module lms_tf_filter_tb_top;
   localparam int L  = 10;
   localparam int N  = 5;
   localparam int MU = 2;
   localparam int AW = 2 * L + $clog2(N + 1);
   localparam int YW = AW - L + 1;
   localparam int EW = YW + 1;
   localparam longint LIM = 64'sd1 <<< (L - 1);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic vld = 1'b0;
   logic [L-1:0] xs = '0;
   logic [L-1:0] ds = '0;
   logic [YW-1:0] y0, y2;
   logic [EW-1:0] e0, e2;

   always #4 clk = ~clk;

   lms_tf_filter #(.L(L), .N(N), .MU_SHIFT(MU), .ADAPT_DELAY(0)) dut_i (
      .clk(clk), .rst(rst), .in_valid(vld), .x_in(xs), .d_in(ds),
      .y_out(y0), .e_out(e0));

   lms_tf_filter #(.L(L), .N(N), .MU_SHIFT(MU), .ADAPT_DELAY(2)) dut_d2_i (
      .clk(clk), .rst(rst), .in_valid(vld), .x_in(xs), .d_in(ds),
      .y_out(y2), .e_out(e2));

   int checks = 0;
   int fails = 0;
   int sat_hits = 0;
   int clamp_hits = 0;
   bit finished = 1'b0;

   // Reference model state, index 0 = delay 0, index 1 = delay 2
   longint mw  [2][N];
   longint mr  [2][N+1];
   longint mxh [2][N+1];
   longint myr [2];
   longint mdr [2];
   longint mer [2];
   longint my  [2];
   longint me  [2];

   function automatic longint clampl(input longint v);
      if (v > LIM - 1) return LIM - 1;
      if (v < -LIM)    return -LIM;
      return v;
   endfunction

   function automatic longint rnd_s();
      return longint'($urandom_range(0, 2 * LIM - 1)) - LIM;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 2; i++) begin
         for (int k = 0; k <= N; k++) begin
            mr[i][k] = 0;
            mxh[i][k] = 0;
         end
         for (int k = 0; k < N; k++) mw[i][k] = 0;
         myr[i] = 0; mdr[i] = 0; mer[i] = 0; my[i] = 0; me[i] = 0;
      end
   endtask

   task automatic model_step(input int i, input longint x, input longint d);
      longint acc, y, e, es, ue, xk, nw, ecomb;
      longint nr [N+1];
      acc = x * mw[i][0] + mr[i][1];
      y = acc >>> (L - 1);
      for (int k = 1; k < N; k++) nr[k] = x * mw[i][k] + mr[i][k+1];
      if (i == 0) begin
         e = y - d;
         es = e >>> MU;
      end else begin
         ecomb = myr[i] - mdr[i];
         e = ecomb;
         es = mer[i] >>> MU;
      end
      ue = clampl(es);
      if (ue != es) clamp_hits++;
      for (int k = 0; k < N; k++) begin
         if (i == 0) xk = (k == 0) ? x : mxh[i][k-1];
         else        xk = mxh[i][k+1];
         nw = mw[i][k] - ((ue * xk) >>> (L - 1));
         if (clampl(nw) != nw) sat_hits++;
         mw[i][k] = clampl(nw);
      end
      for (int k = 1; k < N; k++) mr[i][k] = nr[k];
      for (int j = N; j > 0; j--) mxh[i][j] = mxh[i][j-1];
      mxh[i][0] = x;
      if (i == 0) begin
         my[i] = y;
         me[i] = e;
      end else begin
         my[i] = y;
         me[i] = ecomb;
         myr[i] = y;
         mdr[i] = d;
         mer[i] = ecomb;
      end
   endtask

   task automatic check(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic compare_all(input string ry0, input string re0, input string ry2, input string re2);
      check(ry0, "delay0 y", longint'($signed(y0)), my[0]);
      check(re0, "delay0 e", longint'($signed(e0)), me[0]);
      check(ry2, "delay2 y", longint'($signed(y2)), my[1]);
      check(re2, "delay2 e", longint'($signed(e2)), me[1]);
   endtask

   // One cycle: drive at the falling edge, model on acceptance, sample just after the rising edge
   task automatic cycle(input bit v, input longint x, input longint d,
                        input string ry0, input string re0, input string ry2, input string re2);
      @(negedge clk);
      vld = v;
      xs = x[L-1:0];
      ds = d[L-1:0];
      @(posedge clk);
      if (v) begin
         model_step(0, x, d);
         model_step(1, x, d);
      end
      #1;
      compare_all(ry0, re0, ry2, re2);
   endtask

   initial begin
      int cnt = 0;
      while (!finished && cnt < 20000) begin
         @(posedge clk);
         cnt++;
      end
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=<20000", cnt);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      // R1: reset state
      compare_all("R1", "R1", "R1", "R1");

      // R1: weights start at zero, so the first output is 0 and the error is -d
      cycle(1'b1, 100, 37, "R1", "R1", "R1", "R1");

      // R2 (output), R3 (error), R4/R5 (adaptation seen through later outputs)
      for (int t = 0; t < 150; t++) begin
         cycle(1'b1, rnd_s(), rnd_s() >>> 2, "R2", "R3", "R5", "R3");
         if (t % 10 == 9) cycle(1'b1, rnd_s(), rnd_s(), "R4", "R4", "R5", "R5");
      end

      // R7: strobe low with live data changes nothing
      for (int t = 0; t < 4; t++) cycle(1'b0, rnd_s(), rnd_s(), "R7", "R7", "R7", "R7");
      for (int t = 0; t < 20; t++) cycle(1'b1, rnd_s(), rnd_s(), "R7", "R7", "R7", "R7");

      // R6 and R8: strongly biased inputs drive weights and scaled error to their limits
      for (int t = 0; t < 30; t++) cycle(1'b1, LIM - 1, -LIM, "R6", "R8", "R6", "R8");
      for (int t = 0; t < 30; t++) cycle(1'b1, -LIM, LIM - 1, "R6", "R8", "R6", "R8");
      for (int t = 0; t < 10; t++) cycle(1'b1, (t % 2) ? LIM - 1 : -LIM, 0, "R6", "R8", "R6", "R8");
      checks++;
      if (sat_hits == 0) begin
         fails++;
         $display("FAIL R6 saturation events actual=%0d expected=>0", sat_hits);
      end
      checks++;
      if (clamp_hits == 0) begin
         fails++;
         $display("FAIL R8 clamp events actual=%0d expected=>0", clamp_hits);
      end

      // R7 with sparse strobes interleaved with adaptation
      for (int t = 0; t < 120; t++) begin
         cycle(bit'($urandom_range(0, 1)), rnd_s(), rnd_s() >>> 1, "R7", "R7", "R7", "R7");
      end

      // R1: reset mid-run clears all state again
      @(negedge clk);
      rst = 1'b1;
      vld = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      vld = 1'b0;
      model_reset();
      #1;
      compare_all("R1", "R1", "R1", "R1");
      cycle(1'b1, -300, 55, "R1", "R1", "R1", "R1");
      for (int t = 0; t < 8; t++) cycle(1'b1, rnd_s(), rnd_s(), "R2", "R3", "R5", "R3");

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule